// File: doc/BRIEF.md
# Pipelined Operand Bypass Network

This block sits between a register-file read and a functional unit and finishes collecting a request's source operands while the request travels through a short pipeline. A request enters with one source tag per operand, the value the register file returned for each operand, and a pending flag for each operand. The pending flag says that the register-file value is stale because a newer result is still being produced. The pipeline is as deep as the execution datapath it feeds. Every result bus of every functional unit is broadcast to all stages at once. In each stage, a pending operand whose tag matches a valid result bus takes that result and becomes ready. After the request has passed through all the stages, it leaves with its final operands.

Each stage has a single (N+1):1 select per operand: the held value or one of the N result buses. No stage needs a wide bypass mux covering the whole window. Values older than the bypass window reach the block through the register-file read at entry. Operands whose producer has not appeared by the exit leave still flagged as pending. A stall input freezes the whole pipeline and a flush input empties it.

Top module: `bypass_pipe`

## Requirements
- R1: While the synchronous active-low reset is low, the block holds no valid request, and `out_valid` is 0 in the cycle after reset is released.
- R2: With stall and flush low, a request accepted at a clock edge with `in_valid` high appears on the outputs after exactly DEPTH clock edges. Requests leave in the order they entered. Operand o occupies bits `[o*TAG_W +: TAG_W]` of the tag vectors, `[o*DATA_W +: DATA_W]` of the value vectors and bit o of the pending vectors. Result bus j uses the same slicing with j.
- R3: A pending operand of a valid request takes `res_data` of a valid result bus whose `res_tag` equals its tag, and its pending flag clears. This can happen in any stage, including the cycle in which the request enters.
- R4: Once an operand is not pending, later matching broadcasts leave its value unchanged.
- R5: When several valid result buses match the same pending operand in the same cycle, the one with the lowest index supplies the value.
- R6: An operand that enters with pending 0 leaves with its entry value. A pending operand that never matches leaves with its entry value and pending 1. Tags leave unchanged.
- R7: While `stall` is high and `flush` is low, no stage changes, broadcasts are not captured, and `in_valid` is ignored.
- R8: When `flush` is high at a clock edge, every in-flight request is invalidated and the input is dropped. This holds even if `stall` is also high.
- R9: A result bus whose valid bit is 0 never supplies a value, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Freeze all stages |
| flush | input | 1 | Invalidate all in-flight requests |
| in_valid | input | 1 | Request present at entry |
| in_tag | input | NUM_OPS*TAG_W | Source tag per operand |
| in_val | input | NUM_OPS*DATA_W | Register-file value per operand |
| in_pend | input | NUM_OPS | Operand still awaits a bypass result |
| res_valid | input | NUM_FU | Result bus valid per functional unit |
| res_tag | input | NUM_FU*TAG_W | Result tag per functional unit |
| res_data | input | NUM_FU*DATA_W | Result value per functional unit |
| out_valid | output | 1 | Request present at exit |
| out_tag | output | NUM_OPS*TAG_W | Source tags at exit |
| out_val | output | NUM_OPS*DATA_W | Final operand values |
| out_pend | output | NUM_OPS | Operand never received a bypass result |

## Verification
The bench builds the block with DEPTH=3, NUM_FU=3, NUM_OPS=2, TAG_W=4 and DATA_W=16. With three buses, a three-way collision in one stage can be set up, so the priority order is tested against more than a single pair of buses. With three stages, a capture can be placed at the entry mux, in a middle stage, or after an earlier capture, and a stall can be held while a request sits between the entry and the exit. A behavioural queue model also follows a stream of mixed requests and broadcasts, and it is compared with the outputs on every clock.

// File: rtl/bypass_pkg.sv
// bypass_pkg: default sizes shared by the bypass network and its users.
// Assumes: users override these through module parameters when needed.
package bypass_pkg;
    localparam int DEF_DATA_W  = 32;
    localparam int DEF_TAG_W   = 6;
    localparam int DEF_NUM_OPS = 2;
    localparam int DEF_NUM_FU  = 4;
    localparam int DEF_DEPTH   = 3;
endpackage

// File: rtl/bypass_capture.sv
// bypass_capture: per-operand stage select. It picks the held value or one
// of NUM_FU broadcast results, with the lowest matching bus index winning.
// Assumes: en is the request's valid bit; purely combinational.
module bypass_capture #(
    parameter int NUM_FU = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                     en,
    input  logic                     pend_i,
    input  logic [TAG_W-1:0]         tag_i,
    input  logic [DATA_W-1:0]        val_i,
    input  logic [NUM_FU-1:0]        res_valid,
    input  logic [NUM_FU*TAG_W-1:0]  res_tag,
    input  logic [NUM_FU*DATA_W-1:0] res_data,
    output logic                     pend_o,
    output logic [DATA_W-1:0]        val_o
);
    logic [NUM_FU-1:0] hit;

    // per-bus tag comparator, qualified by the bus valid bit
    for (genvar j = 0; j < NUM_FU; j++) begin : g_cmp
        assign hit[j] = res_valid[j] && (res_tag[j*TAG_W +: TAG_W] == tag_i);
    end

    // priority select: first matching bus in ascending index order
    always_comb begin
        logic found;
        found  = 1'b0;
        val_o  = val_i;
        pend_o = pend_i;
        if (en && pend_i) begin
            for (int j = 0; j < NUM_FU; j++) begin
                if (!found && hit[j]) begin
                    found  = 1'b1;
                    val_o  = res_data[j*DATA_W +: DATA_W];
                    pend_o = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/bypass_stage.sv
// bypass_stage: one register stage of the bypass pipeline. The stage captures
// broadcasts into the incoming request and then registers the result.
// Assumes: stall freezes the stage; flush clears valid and wins over stall.
module bypass_stage #(
    parameter int NUM_OPS = 2,
    parameter int NUM_FU  = 4,
    parameter int TAG_W   = 6,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stall,
    input  logic                      flush,
    input  logic                      d_valid,
    input  logic [NUM_OPS*TAG_W-1:0]  d_tag,
    input  logic [NUM_OPS*DATA_W-1:0] d_val,
    input  logic [NUM_OPS-1:0]        d_pend,
    input  logic [NUM_FU-1:0]         res_valid,
    input  logic [NUM_FU*TAG_W-1:0]   res_tag,
    input  logic [NUM_FU*DATA_W-1:0]  res_data,
    output logic                      q_valid,
    output logic [NUM_OPS*TAG_W-1:0]  q_tag,
    output logic [NUM_OPS*DATA_W-1:0] q_val,
    output logic [NUM_OPS-1:0]        q_pend
);
    logic [NUM_OPS*DATA_W-1:0] c_val;
    logic [NUM_OPS-1:0]        c_pend;

    // one select per operand
    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        bypass_capture #(
            .NUM_FU (NUM_FU),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) cap_i (
            .en        (d_valid),
            .pend_i    (d_pend[o]),
            .tag_i     (d_tag[o*TAG_W +: TAG_W]),
            .val_i     (d_val[o*DATA_W +: DATA_W]),
            .res_valid (res_valid),
            .res_tag   (res_tag),
            .res_data  (res_data),
            .pend_o    (c_pend[o]),
            .val_o     (c_val[o*DATA_W +: DATA_W])
        );

        AST_READY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (!stall && !flush && d_valid && !d_pend[o])
            |=> (!q_pend[o] && q_val[o*DATA_W +: DATA_W] == $past(d_val[o*DATA_W +: DATA_W]))); // R4
        AST_LOW_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (!stall && !flush && d_valid && d_pend[o] && res_valid[0]
             && res_tag[TAG_W-1:0] == d_tag[o*TAG_W +: TAG_W])
            |=> (!q_pend[o] && q_val[o*DATA_W +: DATA_W] == $past(res_data[DATA_W-1:0]))); // R5
    end

    // stage register: reset, flush, hold on stall, else advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
            q_val   <= '0;
            q_pend  <= '0;
        end else if (flush) begin
            q_valid <= 1'b0;
        end else if (!stall) begin
            q_valid <= d_valid;
            q_tag   <= d_tag;
            q_val   <= c_val;
            q_pend  <= c_pend;
        end
    end

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> ($stable(q_valid) && $stable(q_val) && $stable(q_pend))); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !q_valid); // R8
endmodule

// File: rtl/bypass_pipe.sv
// bypass_pipe: DEPTH-stage distributed bypass network in front of one
// functional unit. Every stage sees all result buses and fills in pending
// operands, so no single stage carries the full bypass window.
// Assumes: DEPTH matches the execution pipeline; register-file values arrive
// with the request; one request may enter per unstalled cycle.
module bypass_pipe
    import bypass_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int TAG_W   = DEF_TAG_W,
    parameter int NUM_OPS = DEF_NUM_OPS,
    parameter int NUM_FU  = DEF_NUM_FU,
    parameter int DEPTH   = DEF_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stall,
    input  logic                      flush,
    input  logic                      in_valid,
    input  logic [NUM_OPS*TAG_W-1:0]  in_tag,
    input  logic [NUM_OPS*DATA_W-1:0] in_val,
    input  logic [NUM_OPS-1:0]        in_pend,
    input  logic [NUM_FU-1:0]         res_valid,
    input  logic [NUM_FU*TAG_W-1:0]   res_tag,
    input  logic [NUM_FU*DATA_W-1:0]  res_data,
    output logic                      out_valid,
    output logic [NUM_OPS*TAG_W-1:0]  out_tag,
    output logic [NUM_OPS*DATA_W-1:0] out_val,
    output logic [NUM_OPS-1:0]        out_pend
);
    localparam int TAGS_W = NUM_OPS * TAG_W;
    localparam int VALS_W = NUM_OPS * DATA_W;

    logic [DEPTH:0]      ch_valid;
    logic [TAGS_W-1:0]   ch_tag  [DEPTH+1];
    logic [VALS_W-1:0]   ch_val  [DEPTH+1];
    logic [NUM_OPS-1:0]  ch_pend [DEPTH+1];

    // chain entry is the block input
    assign ch_valid[0] = in_valid;
    assign ch_tag[0]   = in_tag;
    assign ch_val[0]   = in_val;
    assign ch_pend[0]  = in_pend;

    // chain of DEPTH identical stages
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        bypass_stage #(
            .NUM_OPS (NUM_OPS),
            .NUM_FU  (NUM_FU),
            .TAG_W   (TAG_W),
            .DATA_W  (DATA_W)
        ) stage_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .stall     (stall),
            .flush     (flush),
            .d_valid   (ch_valid[s]),
            .d_tag     (ch_tag[s]),
            .d_val     (ch_val[s]),
            .d_pend    (ch_pend[s]),
            .res_valid (res_valid),
            .res_tag   (res_tag),
            .res_data  (res_data),
            .q_valid   (ch_valid[s+1]),
            .q_tag     (ch_tag[s+1]),
            .q_val     (ch_val[s+1]),
            .q_pend    (ch_pend[s+1])
        );
    end

    // chain exit drives the outputs
    assign out_valid = ch_valid[DEPTH];
    assign out_tag   = ch_tag[DEPTH];
    assign out_val   = ch_val[DEPTH];
    assign out_pend  = ch_pend[DEPTH];

    AST_OUT_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R8
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> ($stable(out_valid) && $stable(out_val) && $stable(out_tag))); // R7
    AST_TAG_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !flush) |=> (ch_tag[1] == $past(in_tag))); // R6
endmodule

// File: tb/bypass_pipe_tb.sv
// Bench for bypass_pipe: directed scenarios with hand-computed results plus
// a behavioural queue model compared with the outputs on every clock.
module bypass_pipe_tb_top;
    localparam int DW = 16;
    localparam int TW = 4;
    localparam int NO = 2;
    localparam int NF = 3;
    localparam int DP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 1'b0;
    logic flush = 1'b0;
    logic in_valid = 1'b0;
    logic [NO*TW-1:0] in_tag = '0;
    logic [NO*DW-1:0] in_val = '0;
    logic [NO-1:0]    in_pend = '0;
    logic [NF-1:0]    res_valid = '0;
    logic [NF*TW-1:0] res_tag = '0;
    logic [NF*DW-1:0] res_data = '0;
    logic             out_valid;
    logic [NO*TW-1:0] out_tag;
    logic [NO*DW-1:0] out_val;
    logic [NO-1:0]    out_pend;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bypass_pipe #(.DATA_W(DW), .TAG_W(TW), .NUM_OPS(NO), .NUM_FU(NF), .DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .flush(flush),
        .in_valid(in_valid), .in_tag(in_tag), .in_val(in_val), .in_pend(in_pend),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .out_valid(out_valid), .out_tag(out_tag), .out_val(out_val), .out_pend(out_pend)
    );

    // ---------------- reference model: a queue of DP slots ----------------
    logic          mv [DP];
    logic [TW-1:0] mt [DP][NO];
    logic [DW-1:0] md [DP][NO];
    logic          mp [DP][NO];

    task automatic grab(input int k);
        if (mv[k]) begin
            for (int o = 0; o < NO; o++) begin
                if (mp[k][o]) begin
                    // walk buses from high to low so the lowest match is written last
                    for (int j = NF - 1; j >= 0; j--) begin
                        if (res_valid[j] && res_tag[j*TW +: TW] == mt[k][o]) begin
                            md[k][o] = res_data[j*DW +: DW];
                            mp[k][o] = 1'b0;
                        end
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int k = 0; k < DP; k++) mv[k] = 1'b0;
        end else if (!stall) begin
            for (int k = DP - 1; k > 0; k--) begin
                mv[k] = mv[k-1];
                for (int o = 0; o < NO; o++) begin
                    mt[k][o] = mt[k-1][o]; md[k][o] = md[k-1][o]; mp[k][o] = mp[k-1][o];
                end
                grab(k);
            end
            mv[0] = in_valid;
            for (int o = 0; o < NO; o++) begin
                mt[0][o] = in_tag[o*TW +: TW];
                md[0][o] = in_val[o*DW +: DW];
                mp[0][o] = in_pend[o];
            end
            grab(0);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model comparison on every falling edge after reset
    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk(out_valid == mv[DP-1], "R2 model valid", {31'b0, out_valid}, {31'b0, mv[DP-1]});
            if (mv[DP-1]) begin
                for (int o = 0; o < NO; o++) begin
                    chk(out_val[o*DW +: DW] == md[DP-1][o], "R3 model value",
                        {16'b0, out_val[o*DW +: DW]}, {16'b0, md[DP-1][o]});
                    chk(out_pend[o] == mp[DP-1][o], "R6 model pending",
                        {31'b0, out_pend[o]}, {31'b0, mp[DP-1][o]});
                    chk(out_tag[o*TW +: TW] == mt[DP-1][o], "R6 model tag",
                        {28'b0, out_tag[o*TW +: TW]}, {28'b0, mt[DP-1][o]});
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input logic [TW-1:0] t0, input logic p0, input logic [DW-1:0] v0,
                        input logic [TW-1:0] t1, input logic p1, input logic [DW-1:0] v1);
        in_valid = 1'b1;
        in_tag = {t1, t0};
        in_val = {v1, v0};
        in_pend = {p1, p0};
    endtask

    task automatic quiet();
        in_valid = 1'b0;
        res_valid = '0;
    endtask

    task automatic bus(input int j, input logic v, input logic [TW-1:0] t, input logic [DW-1:0] d);
        res_valid[j] = v;
        res_tag[j*TW +: TW] = t;
        res_data[j*DW +: DW] = d;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(out_valid == 1'b0, "R1 reset valid", {31'b0, out_valid}, 32'd0);
        cmp_on = 1'b1;

        // R2/R3/R4/R5/R6: mid-stage capture, collision, later overwrite attempt
        send(4'd3, 1'b1, 16'hDEAD, 4'd5, 1'b0, 16'h1111);
        step(); quiet(); bus(1, 1'b1, 4'd3, 16'hAAAA); bus(2, 1'b1, 4'd3, 16'hBBBB);
        step(); quiet(); bus(0, 1'b1, 4'd3, 16'hCCCC);
        chk(out_valid == 1'b0, "R2 not early", {31'b0, out_valid}, 32'd0);
        step(); quiet();
        chk(out_valid == 1'b1, "R2 latency", {31'b0, out_valid}, 32'd1);
        chk(out_val[DW-1:0] == 16'hAAAA, "R5 low bus wins / R4 kept", {16'b0, out_val[DW-1:0]}, 32'hAAAA);
        chk(out_pend[0] == 1'b0, "R3 pending cleared", {31'b0, out_pend[0]}, 32'd0);
        chk(out_val[2*DW-1:DW] == 16'h1111, "R6 ready operand kept", {16'b0, out_val[2*DW-1:DW]}, 32'h1111);
        chk(out_tag == {4'd5, 4'd3}, "R6 tags kept", {24'b0, out_tag}, 32'h53);
        step();
        chk(out_valid == 1'b0, "R2 single request", {31'b0, out_valid}, 32'd0);

        // R3 at entry, R9 invalid bus ignored
        send(4'd7, 1'b1, 16'h0101, 4'd9, 1'b1, 16'h0202);
        bus(0, 1'b1, 4'd9, 16'h5555); bus(1, 1'b0, 4'd7, 16'h6666);
        step(); quiet(); bus(2, 1'b0, 4'd7, 16'h6767);
        step(); quiet();
        step(); quiet();
        chk(out_val[DW-1:0] == 16'h0101, "R9 invalid bus ignored", {16'b0, out_val[DW-1:0]}, 32'h0101);
        chk(out_pend[0] == 1'b1, "R9 still pending", {31'b0, out_pend[0]}, 32'd1);
        chk(out_val[2*DW-1:DW] == 16'h5555, "R3 entry capture", {16'b0, out_val[2*DW-1:DW]}, 32'h5555);
        chk(out_pend[1] == 1'b0, "R3 entry pending", {31'b0, out_pend[1]}, 32'd0);
        step();

        // R7: stall freezes and ignores broadcasts and input
        send(4'd2, 1'b1, 16'h0303, 4'd4, 1'b0, 16'h0404);
        step(); quiet(); stall = 1'b1; bus(0, 1'b1, 4'd2, 16'h7777);
        send(4'd2, 1'b1, 16'h0909, 4'd2, 1'b1, 16'h0909);
        step();
        step(); quiet(); stall = 1'b0;
        chk(out_valid == 1'b0, "R7 frozen during stall", {31'b0, out_valid}, 32'd0);
        step();
        chk(out_valid == 1'b0, "R7 delayed", {31'b0, out_valid}, 32'd0);
        step();
        chk(out_valid == 1'b1, "R7 arrives after stall", {31'b0, out_valid}, 32'd1);
        chk(out_val[DW-1:0] == 16'h0303, "R7 broadcast ignored", {16'b0, out_val[DW-1:0]}, 32'h0303);
        chk(out_pend[0] == 1'b1, "R7 still pending", {31'b0, out_pend[0]}, 32'd1);
        step();
        chk(out_valid == 1'b0, "R7 input ignored", {31'b0, out_valid}, 32'd0);

        // R8: flush wins over stall, drops in-flight and input
        send(4'd1, 1'b0, 16'h1010, 4'd1, 1'b0, 16'h2020);
        step();
        step(); flush = 1'b1; stall = 1'b1;
        step(); flush = 1'b0; stall = 1'b0; quiet();
        for (int i = 0; i < DP; i++) begin
            chk(out_valid == 1'b0, "R8 flushed", {31'b0, out_valid}, 32'd0);
            step();
        end

        // R1: reset mid-flight
        send(4'd6, 1'b0, 16'h3030, 4'd6, 1'b0, 16'h4040);
        step(); quiet(); rst_n = 1'b0;
        step(); rst_n = 1'b1;
        for (int i = 0; i < DP; i++) begin
            step();
            chk(out_valid == 1'b0, "R1 reset clears", {31'b0, out_valid}, 32'd0);
        end

        // mixed stream checked by the model (R2 ordering, R3-R6, R9)
        for (int i = 0; i < 40; i++) begin
            send(4'(i % 5), 1'(i % 3 != 0), 16'(i * 97), 4'((i * 3) % 5), 1'(i % 2), 16'(i * 31 + 7));
            for (int j = 0; j < NF; j++)
                bus(j, 1'((i + j) % 3 != 1), 4'((i + 2 * j) % 5), 16'(16'hF000 + i * 8 + j));
            stall = (i % 11 == 10);
            flush = (i == 27);
            step();
        end
        quiet(); stall = 1'b0; flush = 1'b0;
        repeat (DP + 2) step();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule